// File: doc/BRIEF.md
# SPI Command Response Checker

This block sits on the host side of a byte-oriented SPI link to a peripheral. After the host has clocked out a command frame, it keeps clocking the bus to collect the peripheral's reply, and this checker judges that reply one byte at a time. Each command starts with a one-cycle `cmdStart` that carries the issued command code and a flag saying whether trailing CRC bytes are present. The received bytes then arrive as a valid-qualified stream. `rxLast` marks the final byte of the receive window.

The checker discards a lead-in byte for the three control commands. It then requires the command code to be echoed back, followed by a zero status byte. For read commands it hunts for a data-start token, which is any byte whose upper nibble is all ones. The hunt is bounded both by a byte budget and by the end of the window. For register reads it assembles the four payload bytes into a little-endian word and consumes the optional two CRC bytes. It gives one verdict per command: OK, FAIL, or RESET (the link needs resynchronising). It then waits for the next command.

Top module: `rsp_checker`

## Requirements
- R1: After reset, `resultValid` is low and `rdData` is zero, and no result appears until a command is started.
- R2: Command codes are grouped as follows: writes are 0xC1, 0xC3, 0xC7 and 0xC9. Block reads are 0xC2 and 0xC8. Register reads are 0xC4 and 0xCA. Control commands are 0xC5, 0xC6 and 0xCF. Any other code gives a FAIL result in the cycle after `cmdStart`. Result codes are 0 = OK, 1 = FAIL and 2 = RESET.
- R3: For control commands the first received byte is discarded, whatever its value. For every other command the echo is expected in the first byte.
- R4: If the echo byte differs from the issued command code, the result is FAIL.
- R5: The byte after the echo is the status byte. A non-zero status gives FAIL. A zero status completes a write or control command with OK.
- R6: For reads, the bytes after the status are scanned for a token whose bits 7:4 are 0xF. Bytes before it are ignored. A block read finishes with OK on the token.
- R7: A read gives RESET in either of two cases: SCAN_LIMIT (default 100) scanned bytes pass without a token, or the window ends on the status byte or on a non-token scanned byte.
- R8: After the token of a register read, the next four bytes form `rdData` with the first byte in bits 7:0. With `crcEnable` set, two more bytes are consumed before OK is given.
- R9: If the window ends on the token byte, or before all data or CRC bytes of a register read have arrived, the result is FAIL. A token has priority over an exhausted scan budget on the same byte.
- R10: Exactly one result pulse is given per command, one cycle wide. While a command is in progress a new `cmdStart` is ignored. Bytes received while idle are ignored.
- R11: The result pulse is high in the cycle after the deciding byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | One-cycle start of a command check |
| cmdCode | input | 8 | Issued command code, sampled with cmdStart |
| crcEnable | input | 1 | Reply carries two CRC bytes after read data |
| rxValid | input | 1 | rxByte holds a received byte this cycle |
| rxByte | input | 8 | Received byte |
| rxLast | input | 1 | This byte is the last one of the receive window |
| resultValid | output | 1 | One-cycle verdict strobe |
| resultCode | output | 2 | 0 OK, 1 FAIL, 2 RESET |
| rdData | output | 32 | Assembled register-read word, valid with an OK verdict |

## Verification
Token detection can land on the same byte as either the end of the window or the last unit of the scan budget. In each case two verdicts compete. The bench provokes both cases. One stream puts a 0xF0 token as the flagged last byte of the window, and the scoreboard expects FAIL because no payload can follow. Another stream puts a token as exactly the SCAN_LIMIT-th scanned byte, where OK is expected rather than RESET. A sibling stream of SCAN_LIMIT plain bytes, followed by a late token, must give RESET on the last plain byte and nothing afterwards.

// File: rtl/rsp_chk_pkg.sv
package rsp_chk_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_WRITE,
    K_CTRL,
    K_REGRD,
    K_BLKRD
  } cmdKind_t;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_FAIL  = 2'd1,
    RES_RESET = 2'd2
  } result_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftWord;
    logic clrCnt;
    logic incCnt;
  } dpCtl_t;

  function automatic cmdKind_t classifyCode(input logic [7:0] code);
    cmdKind_t k;
    case (code)
      8'hC1, 8'hC3, 8'hC7, 8'hC9: k = K_WRITE;
      8'hC2, 8'hC8:               k = K_BLKRD;
      8'hC4, 8'hCA:               k = K_REGRD;
      8'hC5, 8'hC6, 8'hCF:        k = K_CTRL;
      default:                    k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/rsp_chk_datapath.sv
module rsp_chk_datapath
  import rsp_chk_pkg::*;
#(
  parameter int SCAN_LIMIT = 100,
  parameter int DATA_BYTES = 4,
  parameter int CRC_BYTES  = 2,
  localparam int CNT_W     = $clog2(SCAN_LIMIT + 1),
  localparam int WORD_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [7:0]        startCode,
  input  logic              startCrc,
  input  logic [7:0]        rxByte,
  output cmdKind_t          kind,
  output cmdKind_t          kindNew,
  output logic              crcOn,
  output logic              echoOk,
  output logic              statusZero,
  output logic              hdrHit,
  output logic              scanDone,
  output logic              dataLast,
  output logic              crcLast,
  output logic [WORD_W-1:0] rdData
);

  logic [7:0]       cmdReg;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] word;

  assign kindNew = classifyCode(startCode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= '0;
      kind   <= K_NONE;
      crcOn  <= 1'b0;
    end else if (ctl.loadCmd) begin
      cmdReg <= startCode;
      kind   <= kindNew;
      crcOn  <= startCrc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (ctl.loadCmd || ctl.clrCnt)
      cnt <= '0;
    else if (ctl.incCnt)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word <= '0;
    else if (ctl.loadCmd)
      word <= '0;
    else if (ctl.shiftWord)
      word <= {rxByte, word[WORD_W-1:8]};
  end

  assign rdData     = word;
  assign echoOk     = (rxByte == cmdReg);
  assign statusZero = (rxByte == 8'h00);
  assign hdrHit     = (rxByte[7:4] == 4'hF);
  assign scanDone   = (cnt == CNT_W'(SCAN_LIMIT - 1));
  assign dataLast   = (cnt == CNT_W'(DATA_BYTES - 1));
  assign crcLast    = (cnt == CNT_W'(CRC_BYTES - 1));

  // R7: the shared counter never runs past the scan budget
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(SCAN_LIMIT));

  // R10: control never asks to clear and advance the counter together
  a_r10_cnt_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.clrCnt && ctl.incCnt));

endmodule

// File: rtl/rsp_chk_ctrl.sv
module rsp_chk_ctrl
  import rsp_chk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmdStart,
  input  logic     rxValid,
  input  logic     rxLast,
  input  cmdKind_t kind,
  input  cmdKind_t kindNew,
  input  logic     crcOn,
  input  logic     echoOk,
  input  logic     statusZero,
  input  logic     hdrHit,
  input  logic     scanDone,
  input  logic     dataLast,
  input  logic     crcLast,
  output dpCtl_t   ctl,
  output logic     resultValid,
  output result_t  resultCode
);

  typedef enum logic [2:0] {S_IDLE, S_SKIP, S_ECHO, S_STAT, S_SCAN, S_DATA, S_CRC} state_t;

  state_t  st, nxt;
  logic    fire;
  result_t fireCode;

  always_comb begin
    nxt      = st;
    ctl      = '0;
    fire     = 1'b0;
    fireCode = RES_OK;
    case (st)
      S_IDLE: begin
        if (cmdStart) begin
          if (kindNew == K_NONE) begin
            fire = 1'b1; fireCode = RES_FAIL;
          end else begin
            ctl.loadCmd = 1'b1;
            nxt = (kindNew == K_CTRL) ? S_SKIP : S_ECHO;
          end
        end
      end
      S_SKIP: begin
        if (rxValid) begin
          if (rxLast) begin
            fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
          end else nxt = S_ECHO;
        end
      end
      S_ECHO: begin
        if (rxValid) begin
          if (!echoOk || rxLast) begin
            fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
          end else nxt = S_STAT;
        end
      end
      S_STAT: begin
        if (rxValid) begin
          if (!statusZero) begin
            fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
          end else if (kind == K_WRITE || kind == K_CTRL) begin
            fire = 1'b1; fireCode = RES_OK; nxt = S_IDLE;
          end else if (rxLast) begin
            fire = 1'b1; fireCode = RES_RESET; nxt = S_IDLE;
          end else begin
            ctl.clrCnt = 1'b1; nxt = S_SCAN;
          end
        end
      end
      S_SCAN: begin
        if (rxValid) begin
          if (hdrHit) begin
            if (kind == K_BLKRD) begin
              fire = 1'b1; fireCode = RES_OK; nxt = S_IDLE;
            end else if (rxLast) begin
              fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
            end else begin
              ctl.clrCnt = 1'b1; nxt = S_DATA;
            end
          end else if (rxLast || scanDone) begin
            fire = 1'b1; fireCode = RES_RESET; nxt = S_IDLE;
          end else ctl.incCnt = 1'b1;
        end
      end
      S_DATA: begin
        if (rxValid) begin
          ctl.shiftWord = 1'b1;
          if (dataLast) begin
            if (!crcOn) begin
              fire = 1'b1; fireCode = RES_OK; nxt = S_IDLE;
            end else if (rxLast) begin
              fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
            end else begin
              ctl.clrCnt = 1'b1; nxt = S_CRC;
            end
          end else if (rxLast) begin
            fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
          end else ctl.incCnt = 1'b1;
        end
      end
      S_CRC: begin
        if (rxValid) begin
          if (crcLast) begin
            fire = 1'b1; fireCode = RES_OK; nxt = S_IDLE;
          end else if (rxLast) begin
            fire = 1'b1; fireCode = RES_FAIL; nxt = S_IDLE;
          end else ctl.incCnt = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      resultValid <= 1'b0;
      resultCode  <= RES_OK;
    end else begin
      st          <= nxt;
      resultValid <= fire;
      if (fire) resultCode <= fireCode;
    end
  end

  // R10: a verdict strobe is one cycle wide
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R10: the checker is idle whenever a verdict is shown
  a_r10_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> st == S_IDLE);

  // R2: an unrecognised code is refused on the next cycle
  a_r2_unknown_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmdStart && kindNew == K_NONE) |=> (resultValid && resultCode == RES_FAIL));

  // R4: a wrong echo ends the command with FAIL
  a_r4_echo_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ECHO && rxValid && !echoOk) |=> (resultValid && resultCode == RES_FAIL));

  // R5: a non-zero status ends the command with FAIL
  a_r5_status_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAT && rxValid && !statusZero) |=> (resultValid && resultCode == RES_FAIL));

  // R7: budget exhausted without a token asks for RESET
  a_r7_scan_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && rxValid && !hdrHit && scanDone) |=> (resultValid && resultCode == RES_RESET));

endmodule

// File: rtl/rsp_checker.sv
module rsp_checker
  import rsp_chk_pkg::*;
#(
  parameter int SCAN_LIMIT = 100,
  parameter int DATA_BYTES = 4,
  parameter int CRC_BYTES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmdStart,
  input  logic [7:0]              cmdCode,
  input  logic                    crcEnable,
  input  logic                    rxValid,
  input  logic [7:0]              rxByte,
  input  logic                    rxLast,
  output logic                    resultValid,
  output logic [1:0]              resultCode,
  output logic [8*DATA_BYTES-1:0] rdData
);

  dpCtl_t   ctl;
  cmdKind_t kind, kindNew;
  logic     crcOn, echoOk, statusZero, hdrHit, scanDone, dataLast, crcLast;
  result_t  resCode;

  rsp_chk_datapath #(
    .SCAN_LIMIT(SCAN_LIMIT),
    .DATA_BYTES(DATA_BYTES),
    .CRC_BYTES (CRC_BYTES)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .startCode (cmdCode),
    .startCrc  (crcEnable),
    .rxByte    (rxByte),
    .kind      (kind),
    .kindNew   (kindNew),
    .crcOn     (crcOn),
    .echoOk    (echoOk),
    .statusZero(statusZero),
    .hdrHit    (hdrHit),
    .scanDone  (scanDone),
    .dataLast  (dataLast),
    .crcLast   (crcLast),
    .rdData    (rdData)
  );

  rsp_chk_ctrl uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdStart   (cmdStart),
    .rxValid    (rxValid),
    .rxLast     (rxLast),
    .kind       (kind),
    .kindNew    (kindNew),
    .crcOn      (crcOn),
    .echoOk     (echoOk),
    .statusZero (statusZero),
    .hdrHit     (hdrHit),
    .scanDone   (scanDone),
    .dataLast   (dataLast),
    .crcLast    (crcLast),
    .ctl        (ctl),
    .resultValid(resultValid),
    .resultCode (resCode)
  );

  assign resultCode = resCode;

endmodule

// File: tb/tb_rsp_checker.sv
`timescale 1ns/1ps
module tb_rsp_checker;

  localparam int SCAN_LIMIT = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdStart = 1'b0;
  logic [7:0]  cmdCode = 8'h00;
  logic        crcEnable = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic        rxLast = 1'b0;
  logic        resultValid;
  logic [1:0]  resultCode;
  logic [31:0] rdData;

  rsp_checker #(.SCAN_LIMIT(SCAN_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdCode(cmdCode),
    .crcEnable(crcEnable), .rxValid(rxValid), .rxByte(rxByte), .rxLast(rxLast),
    .resultValid(resultValid), .resultCode(resultCode), .rdData(rdData)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]  code;
    logic [31:0] data;
    bit          chkData;
    int          due;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  win[$];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every verdict
  always @(negedge clk) begin
    if (rst_n && resultValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected result pulse", resultCode, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(resultCode == e.code, e.req, "result code", resultCode, e.code);
        check(cyc == e.due, "R11", {e.req, " result cycle"}, cyc, e.due);
        if (e.chkData)
          check(rdData == e.data, e.req, "read word", rdData, e.data);
      end
    end
  end

  // driver: send the window in win, decide = index of deciding byte (-1: the start)
  task automatic runCmd(input logic [7:0] code, input bit crc, input int decide,
                        input logic [1:0] expCode, input logic [31:0] expData,
                        input bit chk, input string req, input int injectAt);
    exp_t e;
    e.code = expCode; e.data = expData; e.chkData = chk; e.req = req;
    @(posedge clk); #1;
    cmdStart = 1'b1; cmdCode = code; crcEnable = crc;
    if (decide < 0) begin e.due = cyc + 1; sb.push_back(e); end
    @(posedge clk); #1;
    cmdStart = 1'b0;
    for (int i = 0; i < win.size(); i++) begin
      rxValid = 1'b1; rxByte = win[i]; rxLast = (i == win.size() - 1);
      if (i == injectAt) begin cmdStart = 1'b1; cmdCode = 8'h55; end
      if (i == decide) begin e.due = cyc + 1; sb.push_back(e); end
      @(posedge clk); #1;
      cmdStart = 1'b0;
    end
    rxValid = 1'b0; rxLast = 1'b0; rxByte = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check(sb.size() == 0, req, "verdict outstanding after window", sb.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      check(1'b0, "WATCHDOG", "run did not complete", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(resultValid == 1'b0, "R1", "resultValid after reset", resultValid, 0);
    check(rdData == 32'h0, "R1", "rdData after reset", rdData, 0);
    // R10: idle bytes ignored
    @(posedge clk); #1;
    rxValid = 1'b1; rxByte = 8'hC9;
    @(posedge clk); #1;
    rxByte = 8'hF0; rxLast = 1'b1;
    @(posedge clk); #1;
    rxValid = 1'b0; rxLast = 1'b0;
    repeat (2) @(posedge clk);

    // R2: unknown code
    win = {};
    runCmd(8'h55, 1'b0, -1, 2'd1, 32'h0, 1'b0, "R2", -1);

    // R5: write with zero status, trailing dummies ignored
    win = {8'hC9, 8'h00, 8'h00, 8'h00, 8'h00};
    runCmd(8'hC9, 1'b1, 1, 2'd0, 32'h0, 1'b0, "R5", -1);

    // R4: echo mismatch
    win = {8'hC3, 8'h00, 8'h00};
    runCmd(8'hC1, 1'b0, 0, 2'd1, 32'h0, 1'b0, "R4", -1);

    // R5: non-zero status
    win = {8'hC7, 8'h04, 8'h00, 8'h00};
    runCmd(8'hC7, 1'b0, 1, 2'd1, 32'h0, 1'b0, "R5", -1);

    // R3: control commands skip the lead byte
    win = {8'hAA, 8'hC5, 8'h00, 8'h00, 8'h00, 8'h00};
    runCmd(8'hC5, 1'b0, 2, 2'd0, 32'h0, 1'b0, "R3", -1);
    win = {8'h00, 8'hCF, 8'h00, 8'h00, 8'h00};
    runCmd(8'hCF, 1'b0, 2, 2'd0, 32'h0, 1'b0, "R3", -1);
    win = {8'hC6, 8'hC6, 8'h00, 8'h00};
    runCmd(8'hC6, 1'b0, 2, 2'd0, 32'h0, 1'b0, "R3", -1);

    // R8: register read, no CRC, with a busy start injected (R10)
    win = {8'hC4, 8'h00, 8'hF3, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00};
    runCmd(8'hC4, 1'b0, 6, 2'd0, 32'h44332211, 1'b1, "R8", 4);

    // R6/R8: junk before token (0xEF is not a token), CRC consumed
    win = {8'hCA, 8'h00, 8'h01, 8'hEF, 8'hF0, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hC1, 8'hC2, 8'h00};
    runCmd(8'hCA, 1'b1, 10, 2'd0, 32'hEFBEADDE, 1'b1, "R8", -1);

    // R6: block read ends on the token
    win = {8'hC8, 8'h00, 8'h12, 8'hFA, 8'h99, 8'h98};
    runCmd(8'hC8, 1'b0, 3, 2'd0, 32'h0, 1'b0, "R6", -1);

    // R7: scan budget exhausted, a late token is ignored
    win = {8'hC4, 8'h00};
    for (int i = 0; i < SCAN_LIMIT; i++) win.push_back(8'h00);
    win.push_back(8'hF0);
    runCmd(8'hC4, 1'b0, SCAN_LIMIT + 1, 2'd2, 32'h0, 1'b0, "R7", -1);

    // R9: token on the last budget byte wins over exhaustion
    win = {8'hC2, 8'h00};
    for (int i = 0; i < SCAN_LIMIT - 1; i++) win.push_back(8'h00);
    win.push_back(8'hF1);
    runCmd(8'hC2, 1'b0, SCAN_LIMIT + 1, 2'd0, 32'h0, 1'b0, "R9", -1);

    // R7: window ends during scan, and on the status byte
    win = {8'hC4, 8'h00, 8'h00, 8'h00};
    runCmd(8'hC4, 1'b0, 3, 2'd2, 32'h0, 1'b0, "R7", -1);
    win = {8'hCA, 8'h00};
    runCmd(8'hCA, 1'b0, 1, 2'd2, 32'h0, 1'b0, "R7", -1);

    // R9: token is the last window byte
    win = {8'hC4, 8'h00, 8'hF0};
    runCmd(8'hC4, 1'b0, 2, 2'd1, 32'h0, 1'b0, "R9", -1);

    // R9: truncated data, truncated CRC
    win = {8'hC4, 8'h00, 8'hF0, 8'h11, 8'h22};
    runCmd(8'hC4, 1'b0, 4, 2'd1, 32'h0, 1'b0, "R9", -1);
    win = {8'hCA, 8'h00, 8'hF0, 8'h01, 8'h02, 8'h03, 8'h04, 8'hC1};
    runCmd(8'hCA, 1'b1, 7, 2'd1, 32'h0, 1'b0, "R9", -1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule